// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor built around a single accumulator. It runs every instruction as a fixed series of single register transfers between five architectural registers: a program counter, a memory address register, a memory data register, a current instruction register and the accumulator. A controller state machine steps through fetch, decode and execute, and each register changes only in the state that owns its transfer.

The core drives one synchronous memory with a one-cycle read latency. The memory address always comes from the memory address register. A read strobe and a write strobe tell the memory what to do. Read data and write data travel on separate ports. There are four instructions: load, store, add and subtract. Every other opcode does nothing and returns to fetch.

A one-cycle completion pulse marks the last cycle of each instruction. The program counter and accumulator are visible at the ports, so a model outside the core can check the architectural state after every instruction.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter and the accumulator to 0. While it is held, `mem_rd`, `mem_wr` and `instr_done` are 0. This holds even when reset arrives in the middle of an instruction.
- R2: In the first cycle of a fetch, the program counter is copied into the address register and no strobe is active. In the second cycle, `mem_rd` is 1 and `mem_addr` equals the program counter. After reset, the first fetch reads address 0.
- R3: Each instruction adds exactly 1 to the program counter, which is `ADDR_W` bits wide and wraps from 2^ADDR_W-1 to 0.
- R4: An instruction word is `{opcode[3:0], address[ADDR_W-1:0]}`, with the opcode in the top four bits. Opcode 4'b0101 (load) puts the memory word at the address field into the accumulator.
- R5: Opcode 4'b0001 (add) sets the accumulator to the accumulator plus the memory word at the address field, modulo 2^DATA_W, with no flags.
- R6: Opcode 4'b0010 (subtract) sets the accumulator to the accumulator minus the memory word at the address field, modulo 2^DATA_W.
- R7: Opcode 4'b0011 (store) asserts `mem_wr` for one cycle, with `mem_addr` set to the address field and `mem_wdata` set to the accumulator. The accumulator keeps its value.
- R8: Any other opcode is a no-operation. The accumulator is unchanged, no write takes place, and the program counter still advances.
- R9: `instr_done` is high for exactly one cycle per instruction. Counting the reset-release cycle as the first fetch cycle, that cycle is the 5th for a no-operation, the 6th for a store, and the 8th for a load, add or subtract. The updated accumulator and program counter are visible in the following cycle.
- R10: `mem_rd` and `mem_wr` are never high together. Read data is captured in the cycle after the read strobe, which suits a memory with one cycle of read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Memory address, from the address register |
| mem_rd | output | 1 | Read strobe; data is returned one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DATA_W | Write data (the accumulator) |
| mem_rdata | input | DATA_W | Read data from memory |
| instr_done | output | 1 | One-cycle pulse in the last cycle of each instruction |
| pc_o | output | ADDR_W | Program counter |
| acc_o | output | DATA_W | Accumulator |

## Verification
The test program mixes all four opcodes with no-operation words, including opcodes 0000, 0100 and 1111. This separates correct decoding from decoding that only looks at the low opcode bits. The operands are chosen so that add wraps past 2^12 and subtract borrows below zero, which shows the arithmetic is modular and that the two operations are not swapped. A load that follows a store reads back the stored value, which checks the write address and the write data together. The gap between completion pulses tells the three instruction lengths apart. A separate run of 256 instructions pushes the program counter through its wrap, and a reset applied in the middle of a run shows that state clears from any controller state.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OPC_ADD   = 4'b0001;
   localparam logic [OPC_W-1:0] OPC_SUB   = 4'b0010;
   localparam logic [OPC_W-1:0] OPC_STORE = 4'b0011;
   localparam logic [OPC_W-1:0] OPC_LOAD  = 4'b0101;

   typedef enum logic [3:0] {
      ST_F_MAR,   // program counter -> address register
      ST_F_RD,    // read strobe for the instruction word
      ST_F_MDR,   // returned word -> data register
      ST_F_CIR,   // data register -> instruction register, pc + 1
      ST_DEC,     // decode; the address field goes to the address register
      ST_X_RD,    // read strobe for the operand
      ST_X_MDR,   // operand -> data register
      ST_X_ACC,   // ALU result -> accumulator
      ST_X_WR     // accumulator -> memory
   } state_t;

   typedef enum logic [1:0] {
      ALU_PASS,
      ALU_ADD,
      ALU_SUB
   } alu_op_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
   import acc_core_pkg::*;
#(
   parameter int W          = 12,
   parameter bit SUB_ADDER  = 1'b1
) (
   input  alu_op_t        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   y
);

   logic [W-1:0] sum;
   logic [W-1:0] diff;

   assign sum = a + b;

   generate
      if (SUB_ADDER) begin : g_sub_twos
         // subtract by adding the two's complement of b
         assign diff = a + ~b + W'(1);
      end else begin : g_sub_native
         assign diff = a - b;
      end
   endgenerate

   always_comb begin
      case (op)
         ALU_ADD: y = sum;
         ALU_SUB: y = diff;
         default: y = b;
      endcase
   end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
   import acc_core_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] opcode,
   output logic             mar_from_pc,
   output logic             mar_from_ir,
   output logic             mdr_ld,
   output logic             cir_ld,
   output logic             acc_ld,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             done,
   output alu_op_t          alu_op
);

   state_t st_q, st_d;
   logic   op_reads;
   logic   op_writes;

   assign op_reads  = (opcode == OPC_LOAD) || (opcode == OPC_ADD) || (opcode == OPC_SUB);
   assign op_writes = (opcode == OPC_STORE);

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_F_MAR;
      else     st_q <= st_d;
   end

   always_comb begin
      st_d        = st_q;
      mar_from_pc = 1'b0;
      mar_from_ir = 1'b0;
      mdr_ld      = 1'b0;
      cir_ld      = 1'b0;
      acc_ld      = 1'b0;
      mem_rd      = 1'b0;
      mem_wr      = 1'b0;
      done        = 1'b0;
      case (st_q)
         ST_F_MAR: begin mar_from_pc = 1'b1; st_d = ST_F_RD;  end
         ST_F_RD:  begin mem_rd      = 1'b1; st_d = ST_F_MDR; end
         ST_F_MDR: begin mdr_ld      = 1'b1; st_d = ST_F_CIR; end
         ST_F_CIR: begin cir_ld      = 1'b1; st_d = ST_DEC;   end
         ST_DEC: begin
            if (op_reads) begin
               mar_from_ir = 1'b1;
               st_d        = ST_X_RD;
            end else if (op_writes) begin
               mar_from_ir = 1'b1;
               st_d        = ST_X_WR;
            end else begin
               done = 1'b1;
               st_d = ST_F_MAR;
            end
         end
         ST_X_RD:  begin mem_rd = 1'b1; st_d = ST_X_MDR; end
         ST_X_MDR: begin mdr_ld = 1'b1; st_d = ST_X_ACC; end
         ST_X_ACC: begin acc_ld = 1'b1; done = 1'b1; st_d = ST_F_MAR; end
         ST_X_WR:  begin mem_wr = 1'b1; done = 1'b1; st_d = ST_F_MAR; end
         default:  st_d = ST_F_MAR;
      endcase
   end

   always_comb begin
      case (opcode)
         OPC_ADD: alu_op = ALU_ADD;
         OPC_SUB: alu_op = ALU_SUB;
         default: alu_op = ALU_PASS;
      endcase
   end

   // the two strobes never overlap
   assert_rdwr_excl_R10: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   // read data is captured one cycle after the strobe
   assert_mdr_latency_R10: assert property (@(posedge clk) disable iff (rst)
      mem_rd |=> mdr_ld);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_wr_store_R7: assert property (@(posedge clk) disable iff (rst)
      mem_wr |-> (opcode == OPC_STORE));

   assert_wr_after_addr_R7: assert property (@(posedge clk) disable iff (rst)
      mem_wr |-> $past(mar_from_ir));

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_core_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 12,
   parameter bit SUB_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              instr_done,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] acc_o
);

   localparam int OPC_LSB = DATA_W - OPC_W;

   generate
      if (DATA_W != OPC_W + ADDR_W) begin : g_bad_width
         $error("acc_core: DATA_W must equal opcode width plus ADDR_W");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("acc_core: ADDR_W must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] mar_q;
   logic [DATA_W-1:0] mdr_q;
   logic [DATA_W-1:0] cir_q;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] alu_y;

   logic    mar_from_pc, mar_from_ir, mdr_ld, cir_ld, acc_ld;
   alu_op_t alu_op;

   acc_ctrl u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .opcode      (cir_q[DATA_W-1:OPC_LSB]),
      .mar_from_pc (mar_from_pc),
      .mar_from_ir (mar_from_ir),
      .mdr_ld      (mdr_ld),
      .cir_ld      (cir_ld),
      .acc_ld      (acc_ld),
      .mem_rd      (mem_rd),
      .mem_wr      (mem_wr),
      .done        (instr_done),
      .alu_op      (alu_op)
   );

   acc_alu #(
      .W         (DATA_W),
      .SUB_ADDER (SUB_ADDER)
   ) u_alu (
      .op (alu_op),
      .a  (acc_q),
      .b  (mdr_q),
      .y  (alu_y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         mar_q <= '0;
         mdr_q <= '0;
         cir_q <= '0;
         acc_q <= '0;
      end else begin
         if (mar_from_pc)      mar_q <= pc_q;
         else if (mar_from_ir) mar_q <= cir_q[ADDR_W-1:0];
         if (mdr_ld) mdr_q <= mem_rdata;
         if (cir_ld) begin
            cir_q <= mdr_q;
            pc_q  <= pc_q + 1'b1;
         end
         if (acc_ld) acc_q <= alu_y;
      end
   end

   assign mem_addr  = mar_q;
   assign mem_wdata = acc_q;
   assign pc_o      = pc_q;
   assign acc_o     = acc_q;

   // reset leaves pc and accumulator at zero
   logic rst_seen_q;
   always_ff @(posedge clk) begin
      rst_seen_q <= rst;
      if (rst_seen_q) begin
         assert_reset_clear_R1: assert (pc_q == '0 && acc_q == '0);
      end
   end

   assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
      !$stable(pc_q) |-> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

   assert_acc_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !acc_ld |=> $stable(acc_q));

   assert_cir_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !cir_ld |=> $stable(cir_q));

endmodule

// File: tb/acc_core_tb.sv
`timescale 1ns/1ps
module acc_core_tb;

   localparam int AW = 8;
   localparam int DW = 12;
   localparam int NV = 16;

   // {instruction, expected accumulator after it, instruction length in cycles}
   localparam logic [27:0] VEC [0:NV-1] = '{
      {12'h580, 12'h123, 4'd8},   // load 0x80
      {12'h181, 12'h023, 4'd8},   // add, wraps
      {12'h282, 12'h022, 4'd8},   // subtract
      {12'h390, 12'h022, 4'd6},   // store 0x90
      {12'h283, 12'h023, 4'd8},   // subtract 0xFFF
      {12'h055, 12'h023, 4'd5},   // opcode 0000: no-op
      {12'h590, 12'h022, 4'd8},   // load back the stored word
      {12'h280, 12'hEFF, 4'd8},   // subtract, borrows
      {12'h183, 12'hEFE, 4'd8},   // add 0xFFF
      {12'hF80, 12'hEFE, 4'd5},   // opcode 1111: no-op
      {12'h480, 12'hEFE, 4'd5},   // opcode 0100: no-op
      {12'h391, 12'hEFE, 4'd6},   // store 0x91
      {12'h582, 12'h001, 4'd8},
      {12'h282, 12'h000, 4'd8},
      {12'h282, 12'hFFF, 4'd8},   // 0 - 1
      {12'h392, 12'hFFF, 4'd6}    // store 0x92
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] mem_addr;
   logic          mem_rd, mem_wr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          instr_done;
   logic [AW-1:0] pc_o;
   logic [DW-1:0] acc_o;

   logic [DW-1:0] mem [0:(1<<AW)-1];
   logic          tb_we = 1'b0;
   logic [AW-1:0] tb_waddr = '0;
   logic [DW-1:0] tb_wdata = '0;
   int            wr_count = 0;
   int            clash_count = 0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   acc_core u_dut (
      .clk        (clk),
      .rst        (rst),
      .mem_addr   (mem_addr),
      .mem_rd     (mem_rd),
      .mem_wr     (mem_wr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .instr_done (instr_done),
      .pc_o       (pc_o),
      .acc_o      (acc_o)
   );

   // memory with one cycle of read latency
   always @(posedge clk) begin
      if (tb_we) mem[tb_waddr] <= tb_wdata;
      else if (mem_wr) begin
         mem[mem_addr] <= mem_wdata;
         wr_count      <= wr_count + 1;
      end
      if (mem_rd) mem_rdata <= mem[mem_addr];
      if (mem_rd && mem_wr) clash_count <= clash_count + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      tb_we = 1'b1; tb_waddr = a; tb_wdata = d;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic clear_mem();
      for (int i = 0; i < (1 << AW); i++) poke(AW'(i), '0);
   endtask

   // advance to the negedge where instr_done is high; cnt counts cycles
   task automatic wait_done(inout int cnt);
      while (!instr_done && cnt < 40) begin
         @(negedge clk);
         cnt++;
      end
   endtask

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      int cnt;
      int wr0;
      // ---- R1: reset state ----
      clear_mem();
      @(negedge clk);
      chk("R1 pc in reset", pc_o, 0);
      chk("R1 acc in reset", acc_o, 0);
      chk("R1 strobes/done in reset", {mem_rd, mem_wr, instr_done}, 0);

      for (int i = 0; i < NV; i++) poke(AW'(i), VEC[i][27:16]);
      poke(8'h80, 12'h123);
      poke(8'h81, 12'hF00);
      poke(8'h82, 12'h001);
      poke(8'h83, 12'hFFF);

      // ---- R2: first fetch ----
      @(negedge clk);
      rst = 1'b0;                       // this cycle is fetch cycle 1
      chk("R2 no strobe in fetch cycle 1", {mem_rd, mem_wr}, 0);
      @(negedge clk);
      chk("R2 read strobe in fetch cycle 2", mem_rd, 1);
      chk("R2 first fetch address", mem_addr, 0);
      cnt = 2;
      wr0 = wr_count;

      // ---- main program: R4..R9 ----
      for (int i = 0; i < NV; i++) begin
         wait_done(cnt);
         chk($sformatf("R9 length of instr %0d", i), cnt, VEC[i][3:0]);
         @(negedge clk);
         chk($sformatf("R9 done is one pulse, instr %0d", i), instr_done, 0);
         chk($sformatf("R4/R5/R6/R8 acc after instr %0d", i), acc_o, VEC[i][15:4]);
         chk($sformatf("R3 pc after instr %0d", i), pc_o, i + 1);
         cnt = 1;
      end

      chk("R7 stored word at 0x90", mem[8'h90], 12'h022);
      chk("R7 stored word at 0x91", mem[8'h91], 12'hEFE);
      chk("R7 stored word at 0x92", mem[8'h92], 12'hFFF);
      chk("R7/R8 write count", wr_count - wr0, 3);
      chk("R10 no read/write overlap", clash_count, 0);

      // ---- R1: reset in the middle of a run ----
      repeat (3) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 pc after mid-run reset", pc_o, 0);
      chk("R1 acc after mid-run reset", acc_o, 0);
      chk("R1 strobes/done after mid-run reset", {mem_rd, mem_wr, instr_done}, 0);

      // ---- R3: program counter wrap ----
      clear_mem();
      poke(8'hFE, 12'h0AB);             // opcode 0000: no-op
      poke(8'hFF, 12'h5FE);             // load 0xFE
      @(negedge clk);
      rst = 1'b0;
      cnt = 1;
      for (int n = 0; n < (1 << AW); n++) begin
         wait_done(cnt);
         if (cnt >= 40) break;
         @(negedge clk);
         cnt = 1;
      end
      chk("R3 pc wraps to 0", pc_o, 0);
      chk("R4 load at the last address", acc_o, 12'h0AB);
      chk("R10 no read/write overlap at end", clash_count, 0);

      report();
   end

endmodule